// File: doc/BRIEF.md
# Ordered Store Buffer with Write Barrier

This block sits between a processor's store port and its data cache. A store is accepted and retired at once, even when the cache does not yet own the target line. The store waits in a small FIFO until the cache grants ownership of the line held by the oldest entry. The cache grants ownership once every other copy of that line has been invalidated. When the line is granted, the oldest entry is written into the cache.

A write-barrier pulse tags every entry that is in the buffer at that moment. While any tagged entry remains, every later store is kept out of the cache and goes into the buffer behind it, even when that store's line is already owned. When no tagged entry is left, a store to an owned line can go straight to the cache, as long as no older buffered store has the same address and the cache port is not busy with a drain. A parameter selects a second barrier policy in which the store port holds ready low until the tagged entries have drained. A load-address lookup returns the youngest buffered data for a matching address.

Top module: `st_barrier_buf`

## Requirements
- R1: A store presented while `stReady` is high is accepted in that cycle. If its line is not owned (`stOwned` low), it is held in the buffer and does not appear on the cache write port in that cycle.
- R2: When the buffer is not empty and `headOwned` is high, the oldest entry appears on the cache write port in the same cycle and is removed at the next clock edge. At most one entry drains per cycle, and entries leave in arrival order.
- R3: `stReady` is low whenever the buffer holds DEPTH entries.
- R4: A `barrier` pulse tags every entry held before that clock edge. A store accepted in the same cycle is not tagged.
- R5: While any tagged entry remains, or while `barrier` is high with the buffer not empty, an accepted store goes into the buffer and does not write the cache, even if `stOwned` is high.
- R6: With no tagged entry, an accepted store with `stOwned` high goes to the cache write port in the same cycle and is not buffered, provided no buffered entry has the same address and the head is not draining in that cycle. Otherwise the store is buffered.
- R7: `ldHit` is high when any buffered entry's address equals `ldAddr`, and `ldData` then holds the data of the youngest such entry.
- R8: With STALL_ON_BARRIER=1, `stReady` is low while any tagged entry remains, and also while `barrier` is high with the buffer not empty.
- R9: During and right after reset the buffer is empty: `stReady` is high, `ldHit` is low, and the cache write port is idle.
- R10: Once the last tagged entry has drained, the tags are gone, and owned stores go straight to the cache again under the R6 conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request |
| stReady | output | 1 | Store can be accepted |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| stOwned | input | 1 | Cache owns the line of `stAddr` |
| barrier | input | 1 | Write-barrier pulse |
| headAddr | output | AW | Address of the oldest entry, for the ownership query |
| headOwned | input | 1 | Cache owns the line of `headAddr` |
| cacheWrValid | output | 1 | Cache write strobe |
| cacheWrAddr | output | AW | Cache write address |
| cacheWrData | output | DW | Cache write data |
| ldAddr | input | AW | Load lookup address |
| ldHit | output | 1 | A buffered store matches `ldAddr` |
| ldData | output | DW | Youngest matching buffered data |

## Verification
If a tag bit is lost, a store after a barrier reaches the cache write port in its own cycle, ahead of the older entries it should follow. This shows up on the first owned store after the barrier. If a tag bit sticks, owned stores stay buffered, or in stall mode `stReady` stays low, after the drain that should have released them. A pointer or count error shows up within a few cycles, as a wrong address on the drain port or as `stReady` and `ldHit` values that do not agree with the queue the bench expects. The bench drives two instances, one per barrier policy, with the same stimulus.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic push;     // write store into tail
    logic pop;      // write head into cache and retire it
    logic bypass;   // store goes straight to the cache
    logic markAll;  // tag every held entry
  } sbStrobe_t;
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter bit STALL_ON_BARRIER = 1'b0
) (
  input  logic              stValid,
  input  logic              stOwned,
  input  logic              barrier,
  input  logic              headOwned,
  input  logic              bufEmpty,
  input  logic              bufFull,
  input  logic              anyMarked,
  input  logic              stHitBuf,
  output logic              stReady,
  output sb_pkg::sbStrobe_t strobe
);
  logic markActive;
  logic drainNow;

  // a barrier in this cycle orders the same-cycle store behind held entries
  assign markActive = anyMarked | (barrier & ~bufEmpty);
  assign drainNow   = ~bufEmpty & headOwned;

  generate
    if (STALL_ON_BARRIER) begin : g_stall
      assign stReady = ~bufFull & ~markActive;
    end else begin : g_divert
      assign stReady = ~bufFull;
    end
  endgenerate

  always_comb begin
    strobe.pop     = drainNow;
    strobe.markAll = barrier;
    strobe.bypass  = stValid & stReady & stOwned & ~markActive & ~stHitBuf & ~drainNow;
    strobe.push    = stValid & stReady & ~strobe.bypass;
  end
endmodule

// File: rtl/sb_data.sv
module sb_data #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = PTRW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sb_pkg::sbStrobe_t strobe,
  input  logic [AW-1:0]     stAddr,
  input  logic [DW-1:0]     stData,
  input  logic [AW-1:0]     ldAddr,
  output logic              bufEmpty,
  output logic              bufFull,
  output logic              anyMarked,
  output logic              stHitBuf,
  output logic [CNTW-1:0]   count,
  output logic [AW-1:0]     headAddr,
  output logic              cacheWrValid,
  output logic [AW-1:0]     cacheWrAddr,
  output logic [DW-1:0]     cacheWrData,
  output logic              ldHit,
  output logic [DW-1:0]     ldData
);
  logic [AW-1:0]    addrQ [DEPTH];
  logic [DW-1:0]    dataQ [DEPTH];
  logic [DEPTH-1:0] markQ;
  logic [DEPTH-1:0] validV;
  logic [PTRW-1:0]  headPtr, tailPtr;

  assign bufEmpty  = (count == '0);
  assign bufFull   = (count == CNTW'(DEPTH));
  assign anyMarked = |markQ;
  assign headAddr  = addrQ[headPtr];

  // slot occupancy from its age relative to the head
  always_comb begin
    logic [PTRW-1:0] age;
    for (int i = 0; i < DEPTH; i++) begin
      age       = PTRW'(i) - headPtr;
      validV[i] = ({1'b0, age} < count);
    end
  end

  always_comb begin
    stHitBuf = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (validV[i] && addrQ[i] == stAddr) stHitBuf = 1'b1;
  end

  // walk oldest to youngest; the last match wins
  always_comb begin
    logic [PTRW-1:0] idx;
    ldHit  = 1'b0;
    ldData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = headPtr + PTRW'(k);
      if (CNTW'(k) < count && addrQ[idx] == ldAddr) begin
        ldHit  = 1'b1;
        ldData = dataQ[idx];
      end
    end
  end

  assign cacheWrValid = strobe.pop | strobe.bypass;
  assign cacheWrAddr  = strobe.pop ? addrQ[headPtr] : stAddr;
  assign cacheWrData  = strobe.pop ? dataQ[headPtr] : stData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
      markQ   <= '0;
    end else begin
      if (strobe.push) begin
        addrQ[tailPtr] <= stAddr;
        dataQ[tailPtr] <= stData;
        tailPtr        <= tailPtr + 1'b1;
      end
      if (strobe.pop) headPtr <= headPtr + 1'b1;
      count <= count + CNTW'(strobe.push) - CNTW'(strobe.pop);
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.pop && PTRW'(i) == headPtr)      markQ[i] <= 1'b0;
        else if (strobe.markAll && validV[i])       markQ[i] <= 1'b1;
        else if (strobe.push && PTRW'(i) == tailPtr) markQ[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/st_barrier_buf.sv
module st_barrier_buf #(
  parameter int AW               = 16,
  parameter int DW               = 32,
  parameter int DEPTH            = 4,   // power of two, at least 2
  parameter bit STALL_ON_BARRIER = 1'b0,
  localparam int CNTW            = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  output logic          stReady,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          stOwned,
  input  logic          barrier,
  output logic [AW-1:0] headAddr,
  input  logic          headOwned,
  output logic          cacheWrValid,
  output logic [AW-1:0] cacheWrAddr,
  output logic [DW-1:0] cacheWrData,
  input  logic [AW-1:0] ldAddr,
  output logic          ldHit,
  output logic [DW-1:0] ldData
);
  sb_pkg::sbStrobe_t strobe;
  logic              bufEmpty, bufFull, anyMarked, stHitBuf;
  logic [CNTW-1:0]   count;

  sb_ctrl #(.STALL_ON_BARRIER(STALL_ON_BARRIER)) u_ctrl (
    .stValid(stValid), .stOwned(stOwned), .barrier(barrier), .headOwned(headOwned),
    .bufEmpty(bufEmpty), .bufFull(bufFull), .anyMarked(anyMarked), .stHitBuf(stHitBuf),
    .stReady(stReady), .strobe(strobe)
  );

  sb_data #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stAddr(stAddr), .stData(stData),
    .ldAddr(ldAddr), .bufEmpty(bufEmpty), .bufFull(bufFull), .anyMarked(anyMarked),
    .stHitBuf(stHitBuf), .count(count), .headAddr(headAddr),
    .cacheWrValid(cacheWrValid), .cacheWrAddr(cacheWrAddr), .cacheWrData(cacheWrData),
    .ldHit(ldHit), .ldData(ldData)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH            = 4,
  parameter bit STALL_ON_BARRIER = 1'b0,
  localparam int CNTW            = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              stValid,
  input logic              stReady,
  input logic              headOwned,
  input logic              cacheWrValid,
  input logic [CNTW-1:0]   count,
  input logic              anyMarked,
  input sb_pkg::sbStrobe_t strobe
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH)); // R3
  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNTW'(DEPTH)) |-> !stReady); // R3
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.pop && strobe.bypass)); // R2
  AST_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    cacheWrValid |-> (headOwned || (stValid && stReady))); // R2
  AST_MARK_NO_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    anyMarked |-> !strobe.bypass); // R5
  AST_MARK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> !anyMarked); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (STALL_ON_BARRIER && anyMarked) |-> !stReady); // R8
endmodule

bind st_barrier_buf sb_checker #(.DEPTH(DEPTH), .STALL_ON_BARRIER(STALL_ON_BARRIER)) u_chk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady), .headOwned(headOwned),
  .cacheWrValid(cacheWrValid), .count(count), .anyMarked(anyMarked), .strobe(strobe)
);

// File: tb/test_st_barrier_buf.sv
module test_st_barrier_buf;
  localparam int AW = 16, DW = 32, DEPTH = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic stValid = 0, stOwned = 0, barrier = 0, headOwned = 0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [DW-1:0] stData = '0;

  logic          rdyO [2];
  logic          wrVO [2];
  logic [AW-1:0] wrAO [2];
  logic [DW-1:0] wrDO [2];
  logic          ldHO [2];
  logic [DW-1:0] ldDO [2];
  logic [AW-1:0] hdAO [2];

  int checks = 0, fails = 0;

  // bench model: index 0 is the oldest entry
  logic [AW-1:0] mAddr [2][DEPTH];
  logic [DW-1:0] mData [2][DEPTH];
  logic          mMark [2][DEPTH];
  int            mCnt  [2];
  bit            sawBarrier [2];

  always #10 clk = ~clk;

  st_barrier_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .STALL_ON_BARRIER(1'b0)) i_st_barrier_buf (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(rdyO[0]), .stAddr(stAddr),
    .stData(stData), .stOwned(stOwned), .barrier(barrier), .headAddr(hdAO[0]),
    .headOwned(headOwned), .cacheWrValid(wrVO[0]), .cacheWrAddr(wrAO[0]),
    .cacheWrData(wrDO[0]), .ldAddr(ldAddr), .ldHit(ldHO[0]), .ldData(ldDO[0]));

  st_barrier_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .STALL_ON_BARRIER(1'b1)) i_st_barrier_buf_stall (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(rdyO[1]), .stAddr(stAddr),
    .stData(stData), .stOwned(stOwned), .barrier(barrier), .headAddr(hdAO[1]),
    .headOwned(headOwned), .cacheWrValid(wrVO[1]), .cacheWrAddr(wrAO[1]),
    .cacheWrData(wrDO[1]), .ldAddr(ldAddr), .ldHit(ldHO[1]), .ldData(ldDO[1]));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit modelAnyMark(int m);
    for (int j = 0; j < DEPTH; j++) if (j < mCnt[m] && mMark[m][j]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit modelHit(int m, logic [AW-1:0] a);
    for (int j = 0; j < DEPTH; j++) if (j < mCnt[m] && mAddr[m][j] == a) return 1'b1;
    return 1'b0;
  endfunction

  // compares one instance against the model, then advances the model state
  task automatic stepModel(int m);
    bit markAct, ready, drain, byp, push, expHit;
    logic [DW-1:0] expLd;
    string wtag;
    markAct = modelAnyMark(m) || (barrier && mCnt[m] > 0);
    ready   = (mCnt[m] < DEPTH) && !(m == 1 && markAct);
    drain   = (mCnt[m] > 0) && headOwned;
    byp     = stValid && ready && stOwned && !markAct && !modelHit(m, stAddr) && !drain;
    push    = stValid && ready && !byp;
    chk((mCnt[m] == DEPTH) ? "R3 ready when full" : (m == 1 ? "R8 stall ready" : "R3 ready"),
        64'(rdyO[m]), 64'(ready));
    if (drain)                                  wtag = "R2 drain";
    else if (byp && sawBarrier[m])              wtag = "R10 bypass after drain";
    else if (byp)                               wtag = "R6 bypass";
    else if (push && stOwned && markAct)        wtag = "R5 diverted store";
    else                                        wtag = "R1 buffered store";
    chk(wtag, 64'(wrVO[m]), 64'(drain || byp));
    if (drain) begin
      chk("R2 drain addr", 64'(wrAO[m]), 64'(mAddr[m][0]));
      chk("R2 drain data", 64'(wrDO[m]), 64'(mData[m][0]));
    end else if (byp) begin
      chk("R6 bypass data", 64'(wrDO[m]), 64'(stData));
    end
    expHit = 1'b0; expLd = '0;
    for (int j = 0; j < DEPTH; j++)
      if (j < mCnt[m] && mAddr[m][j] == ldAddr) begin expHit = 1'b1; expLd = mData[m][j]; end
    chk("R7 load hit", 64'(ldHO[m]), 64'(expHit));
    if (expHit) chk("R7 youngest data", 64'(ldDO[m]), 64'(expLd));
    if (barrier && mCnt[m] > 0) sawBarrier[m] = 1'b1;
    if (byp) sawBarrier[m] = 1'b0;
    if (barrier) for (int j = 0; j < DEPTH; j++) if (j < mCnt[m]) mMark[m][j] = 1'b1;
    if (drain) begin
      for (int j = 0; j < DEPTH - 1; j++) begin
        mAddr[m][j] = mAddr[m][j+1]; mData[m][j] = mData[m][j+1]; mMark[m][j] = mMark[m][j+1];
      end
      mCnt[m]--;
    end
    if (push) begin
      mAddr[m][mCnt[m]] = stAddr; mData[m][mCnt[m]] = stData; mMark[m][mCnt[m]] = 1'b0;
      mCnt[m]++;
    end
  endtask

  task automatic cycle(bit v, logic [AW-1:0] a, logic [DW-1:0] d, bit own, bit bar, bit hown,
                       logic [AW-1:0] la);
    @(negedge clk);
    stValid = v; stAddr = a; stData = d; stOwned = own; barrier = bar; headOwned = hown; ldAddr = la;
    #5;
    stepModel(0);
    stepModel(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int m = 0; m < 2; m++) begin mCnt[m] = 0; sawBarrier[m] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk); headOwned = 1'b1; #5;
    for (int m = 0; m < 2; m++) begin
      chk("R9 reset ready", 64'(rdyO[m]), 64'd1);
      chk("R9 reset no write", 64'(wrVO[m]), 64'd0);
      chk("R9 reset no hit", 64'(ldHO[m]), 64'd0);
    end
    @(negedge clk); rstN = 1'b1;

    // directed: unowned store, barrier, owned store held back, drain, resumed bypass
    cycle(1, 16'h0010, 32'h11, 0, 0, 0, 16'h0010);  // R1
    cycle(0, 16'h0000, 32'h0,  0, 1, 0, 16'h0010);  // R4 tag
    cycle(1, 16'h0020, 32'h22, 1, 0, 0, 16'h0020);  // R5 / R8
    cycle(0, 16'h0000, 32'h0,  0, 0, 1, 16'h0020);
    cycle(0, 16'h0000, 32'h0,  0, 0, 1, 16'h0020);
    cycle(1, 16'h0030, 32'h33, 1, 0, 0, 16'h0030);  // R10
    // directed: same address twice then fill to full
    cycle(1, 16'h0040, 32'hA1, 0, 0, 0, 16'h0040);
    cycle(1, 16'h0040, 32'hA2, 1, 0, 0, 16'h0040);  // R6 blocked by match, R7 youngest
    cycle(1, 16'h0050, 32'hB1, 0, 0, 0, 16'h0040);
    cycle(1, 16'h0060, 32'hC1, 0, 0, 0, 16'h0040);
    cycle(1, 16'h0070, 32'hD1, 1, 0, 0, 16'h0040);  // R3 full
    for (int k = 0; k < 5; k++) cycle(0, 16'h0, 32'h0, 0, 0, 1, 16'h0040);

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      cycle(($urandom % 10) < 7, AW'($urandom % 8), $urandom, $urandom % 2,
            ($urandom % 10) == 0, ($urandom % 10) < 4, AW'($urandom % 8));
    end
    for (int k = 0; k < 6; k++) cycle(0, 16'h0, 32'h0, 0, 0, 1, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule